// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps a 16-bit virtual address onto a physical address through a table of 128 page descriptors held inside the unit. Memory is split into 512-byte pages. The low nine address bits pass through unchanged as the offset, and the upper seven bits select a descriptor. Each descriptor holds a frame number, a valid flag, a not-resident flag, a dirty flag, three access-permission flags and a swap-block field that the unit never interprets. Every access carries an access type: data load, data store or instruction fetch. The unit either returns the physical address or reports one of two faults. A protection fault covers an invalid page or a missing permission. A residency fault covers a page that is permitted but currently swapped out.

Software fills the table and switches translation on or off through a configuration port. That port honours writes only while the privilege input is high. A write attempted without privilege is dropped and flagged on a one-cycle illegal-operation output. The same port also reads back a descriptor, so software can see which pages the hardware has marked dirty. While translation is off, addresses pass straight through and nothing is checked. Each request is answered one clock after it is presented, and the address and fault flags arrive together.

Top module: `pt_xlate`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `rsp_vld`, `rsp_seg_fault`, `rsp_page_fault` and `illegal_op` are low. Translation comes out of reset disabled.
- R2: A request presented with `req_vld` high at a rising edge produces `rsp_vld` high, together with its address and fault flags, right after that edge. With no request at an edge, `rsp_vld` is low after it.
- R3: While translation is disabled, `rsp_pa` equals `req_va`, neither fault flag is raised, and no descriptor is changed.
- R4: With translation enabled and no fault, `rsp_pa` is the descriptor's frame number (bits [6:0]) placed above the untouched offset `req_va[8:0]`. The descriptor is selected by `req_va[15:9]`.
- R5: With translation enabled, `rsp_seg_fault` is raised and `rsp_pa` is 0 in two cases. The first is a valid bit (bit 7) of 0. The second is a clear permission bit for the access type. Type 0 (load) needs bit 10, type 1 (store) needs bit 11, type 2 (fetch) needs bit 12, and type 3 is never permitted.
- R6: With translation enabled, a valid and permitted access whose not-resident bit (bit 8) is 1 raises `rsp_page_fault`, with `rsp_pa` 0 and `rsp_seg_fault` low.
- R7: A protection fault takes precedence over a residency fault. An invalid page whose not-resident bit is set still reports `rsp_seg_fault` only.
- R8: A permitted store to a valid, resident page sets that descriptor's dirty bit (bit 9) at the same edge that registers the response.
- R9: With `cfg_priv` high, a `cfg_we` pulse does one of two things. With `cfg_ctl` low it writes `cfg_wdata` into the descriptor at `cfg_idx`. With `cfg_ctl` high it loads the translation enable from `cfg_wdata[0]`. `cfg_rdata` returns the descriptor at `cfg_idx` one cycle after the index is presented.
- R10: A `cfg_we` pulse with `cfg_priv` low changes neither the table nor the enable, and raises `illegal_op` for exactly the following cycle.
- R11: When a request and a privileged descriptor write hit the same page in one cycle, the request is judged against the old descriptor. The written value is what remains, including its dirty bit, even if the request was a store that would have set it.
- R12: Loads, fetches, faulting stores and stores made while translation is disabled leave the dirty bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Translation request strobe |
| req_op | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| req_va | input | 16 | Virtual address |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 16 | Physical address (0 on a fault) |
| rsp_seg_fault | output | 1 | Protection or invalid-page fault |
| rsp_page_fault | output | 1 | Page not resident |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctl | input | 1 | 1 selects the enable register, 0 selects a descriptor |
| cfg_priv | input | 1 | Privilege level of the configuration access |
| cfg_idx | input | 7 | Descriptor index for write and read-back |
| cfg_wdata | input | 32 | Descriptor or control data |
| cfg_rdata | output | 32 | Descriptor read back, one cycle after `cfg_idx` |
| illegal_op | output | 1 | One-cycle pulse after an unprivileged write |

## Verification
Two activities can meet in one cycle: the hardware dirty-bit update from a translated store, and a software rewrite of the same descriptor. The bench provokes this by presenting a store to a page at the same clock edge as a privileged write to that page's descriptor. It then checks two results. The response must carry the frame of the old descriptor. The read-back must show exactly the written word, with no dirty bit added. A second store afterwards must translate through the new frame and set the dirty bit, which shows that the table stayed usable.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_op_e;

  localparam int FRAME_W = 7;
  localparam int B_VALID = FRAME_W;
  localparam int B_AWAY  = FRAME_W + 1;
  localparam int B_DIRTY = FRAME_W + 2;
  localparam int B_RD    = FRAME_W + 3;
  localparam int B_WR    = FRAME_W + 4;
  localparam int B_EX    = FRAME_W + 5;
endpackage

// File: rtl/pt_table.sv
module pt_table
  import pt_xlate_pkg::*;
#(
  parameter int ENT_W = 32,
  parameter int PG_W  = 7
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PG_W-1:0]  wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             dset_en,
  input  logic [PG_W-1:0]  dset_idx,
  input  logic [PG_W-1:0]  lk_idx,
  output logic [ENT_W-1:0] lk_entry,
  input  logic [PG_W-1:0]  rd_idx,
  output logic [ENT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << PG_W;

  logic [ENT_W-1:0] mem [DEPTH];

  // Hardware dirty marking first; a software write in the same cycle wins.
  always_ff @(posedge clk) begin
    if (dset_en) mem[dset_idx][B_DIRTY] <= 1'b1;
    if (wr_en)   mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  assign lk_entry = mem[lk_idx];
endmodule

// File: rtl/pt_check.sv
module pt_check
  import pt_xlate_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFS_W = 9,
  parameter int ENT_W = 32
) (
  input  logic             en,
  input  logic             vld,
  input  logic [1:0]       op,
  input  logic [VA_W-1:0]  va,
  input  logic [ENT_W-1:0] entry,
  output logic [VA_W-1:0]  pa,
  output logic             seg,
  output logic             away,
  output logic             mark_dirty
);
  logic perm;
  logic ok_valid;
  logic ok_home;

  always_comb begin
    unique case (acc_op_e'(op))
      ACC_LOAD:  perm = entry[B_RD];
      ACC_STORE: perm = entry[B_WR];
      ACC_FETCH: perm = entry[B_EX];
      default:   perm = 1'b0;
    endcase
    ok_valid = entry[B_VALID];
    ok_home  = !entry[B_AWAY];
  end

  always_comb begin
    if (!en) begin
      pa         = va;
      seg        = 1'b0;
      away       = 1'b0;
      mark_dirty = 1'b0;
    end else begin
      seg        = vld && !(ok_valid && perm);
      away       = vld && ok_valid && perm && !ok_home;
      mark_dirty = vld && (acc_op_e'(op) == ACC_STORE) && ok_valid && perm && ok_home;
      if (!(ok_valid && perm && ok_home)) pa = '0;
      else pa = VA_W'({entry[FRAME_W-1:0], va[OFS_W-1:0]});
    end
  end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFS_W = 9,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic [1:0]       req_op,
  input  logic [VA_W-1:0]  req_va,
  output logic             rsp_vld,
  output logic [VA_W-1:0]  rsp_pa,
  output logic             rsp_seg_fault,
  output logic             rsp_page_fault,
  input  logic             cfg_we,
  input  logic             cfg_ctl,
  input  logic             cfg_priv,
  input  logic [VA_W-OFS_W-1:0] cfg_idx,
  input  logic [ENT_W-1:0] cfg_wdata,
  output logic [ENT_W-1:0] cfg_rdata,
  output logic             illegal_op
);
  localparam int PG_W = VA_W - OFS_W;

  logic             xl_en;
  logic [ENT_W-1:0] lk_entry;
  logic [VA_W-1:0]  nx_pa;
  logic             nx_seg;
  logic             nx_away;
  logic             mark_dirty;
  logic             tbl_we;
  logic             ctl_we;
  logic [PG_W-1:0]  req_pg;

  assign req_pg = req_va[VA_W-1:OFS_W];
  assign tbl_we = cfg_we && cfg_priv && !cfg_ctl;
  assign ctl_we = cfg_we && cfg_priv && cfg_ctl;

  pt_table #(.ENT_W(ENT_W), .PG_W(PG_W)) u_table (
    .clk      (clk),
    .wr_en    (tbl_we),
    .wr_idx   (cfg_idx),
    .wr_data  (cfg_wdata),
    .dset_en  (mark_dirty),
    .dset_idx (req_pg),
    .lk_idx   (req_pg),
    .lk_entry (lk_entry),
    .rd_idx   (cfg_idx),
    .rd_data  (cfg_rdata)
  );

  pt_check #(.VA_W(VA_W), .OFS_W(OFS_W), .ENT_W(ENT_W)) u_check (
    .en         (xl_en),
    .vld        (req_vld),
    .op         (req_op),
    .va         (req_va),
    .entry      (lk_entry),
    .pa         (nx_pa),
    .seg        (nx_seg),
    .away       (nx_away),
    .mark_dirty (mark_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_en          <= 1'b0;
      rsp_vld        <= 1'b0;
      rsp_pa         <= '0;
      rsp_seg_fault  <= 1'b0;
      rsp_page_fault <= 1'b0;
      illegal_op     <= 1'b0;
    end else begin
      if (ctl_we) xl_en <= cfg_wdata[0];
      rsp_vld        <= req_vld;
      rsp_pa         <= req_vld ? nx_pa : '0;
      rsp_seg_fault  <= nx_seg;
      rsp_page_fault <= nx_away;
      illegal_op     <= cfg_we && !cfg_priv;
    end
  end
endmodule

// File: rtl/pt_xlate_sva.sv
module pt_xlate_sva #(
  parameter int VA_W  = 16,
  parameter int OFS_W = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            req_vld,
  input logic [VA_W-1:0] req_va,
  input logic            rsp_vld,
  input logic [VA_W-1:0] rsp_pa,
  input logic            rsp_seg_fault,
  input logic            rsp_page_fault,
  input logic            cfg_we,
  input logic            cfg_priv,
  input logic            illegal_op,
  input logic            xl_en
);
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rsp_seg_fault && rsp_page_fault)); // R7
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_seg_fault || rsp_page_fault) |-> (rsp_vld && rsp_pa == '0)); // R5
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld); // R2
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !xl_en) |=> (rsp_pa == $past(req_va) && !rsp_seg_fault && !rsp_page_fault)); // R3
  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (rst)
    (req_vld && xl_en) |=> ((rsp_seg_fault || rsp_page_fault) ||
                           rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0]))); // R4
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_priv) |=> illegal_op); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && !cfg_priv) |=> !illegal_op); // R10
endmodule

bind pt_xlate pt_xlate_sva #(.VA_W(VA_W), .OFS_W(OFS_W)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .req_vld        (req_vld),
  .req_va         (req_va),
  .rsp_vld        (rsp_vld),
  .rsp_pa         (rsp_pa),
  .rsp_seg_fault  (rsp_seg_fault),
  .rsp_page_fault (rsp_page_fault),
  .cfg_we         (cfg_we),
  .cfg_priv       (cfg_priv),
  .illegal_op     (illegal_op),
  .xl_en          (xl_en)
);

// File: tb/pt_xlate_test.sv
module pt_xlate_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_vld;
  logic [1:0]  req_op;
  logic [15:0] req_va;
  logic        rsp_vld;
  logic [15:0] rsp_pa;
  logic        rsp_seg_fault;
  logic        rsp_page_fault;
  logic        cfg_we;
  logic        cfg_ctl;
  logic        cfg_priv;
  logic [6:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        illegal_op;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  pt_xlate uut (.*);

  // Vector: {req tag, op, va, seg, page, pa}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {4'd5, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R5 invalid page
    {4'd4, 2'd0, 16'h0234, 1'b0, 1'b0, 16'h0A34},  // R4 load, frame 5
    {4'd5, 2'd1, 16'h0234, 1'b1, 1'b0, 16'h0000},  // R5 store without write bit
    {4'd5, 2'd2, 16'h03FF, 1'b1, 1'b0, 16'h0000},  // R5 fetch without exec bit
    {4'd4, 2'd0, 16'h05FF, 1'b0, 1'b0, 16'hFFFF},  // R4 top frame, top offset
    {4'd4, 2'd2, 16'h0400, 1'b0, 1'b0, 16'hFE00},  // R4 fetch
    {4'd6, 2'd0, 16'h0610, 1'b0, 1'b1, 16'h0000},  // R6 swapped out, load
    {4'd6, 2'd1, 16'h0610, 1'b0, 1'b1, 16'h0000},  // R6 swapped out, store
    {4'd7, 2'd0, 16'h0800, 1'b1, 1'b0, 16'h0000},  // R7 invalid and swapped out
    {4'd4, 2'd2, 16'hFE21, 1'b0, 1'b0, 16'h0221},  // R4 last page
    {4'd5, 2'd0, 16'hFE21, 1'b1, 1'b0, 16'h0000},  // R5 exec-only page loaded
    {4'd5, 2'd3, 16'h0400, 1'b1, 1'b0, 16'h0000}   // R5 reserved type
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [1:0] op, input logic [15:0] va);
    @(negedge clk);
    req_vld = 1'b1; req_op = op; req_va = va;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic cfg_write(input logic ctl, input logic [6:0] idx,
                           input logic [31:0] data, input logic priv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctl = ctl; cfg_idx = idx; cfg_wdata = data; cfg_priv = priv;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic read_entry(input logic [6:0] idx, output logic [31:0] val);
    @(negedge clk);
    cfg_idx = idx;
    @(negedge clk);
    val = cfg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_vld = 1'b0; req_op = 2'd0; req_va = '0;
    cfg_we = 1'b0; cfg_ctl = 1'b0; cfg_priv = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 outputs", {28'd0, rsp_vld, rsp_seg_fault, rsp_page_fault, illegal_op}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {28'd0, rsp_vld, rsp_seg_fault, rsp_page_fault, illegal_op}, 32'd0);

    // R3: disabled out of reset, pass-through
    xlate(2'd1, 16'h1234);
    chk("R3 pa", {16'd0, rsp_pa}, 32'h1234);
    chk("R3 faults", {30'd0, rsp_seg_fault, rsp_page_fault}, 32'd0);
    chk("R2 rsp_vld", {31'd0, rsp_vld}, 32'd1);

    // R9: load the table and enable translation
    cfg_write(1'b0, 7'd0,   32'h0000_0000, 1'b1);
    cfg_write(1'b0, 7'd1,   32'h0000_0485, 1'b1);
    cfg_write(1'b0, 7'd2,   32'h0000_1CFF, 1'b1);
    cfg_write(1'b0, 7'd3,   32'h0000_1D83, 1'b1);
    cfg_write(1'b0, 7'd4,   32'h0000_1D04, 1'b1);
    cfg_write(1'b0, 7'd127, 32'hABCD_1081, 1'b1);
    cfg_write(1'b1, 7'd0,   32'h0000_0001, 1'b1);
    read_entry(7'd127, rd);
    chk("R9 readback", rd, 32'hABCD_1081);

    // R10: unprivileged writes are dropped and flagged
    cfg_write(1'b0, 7'd1, 32'hFFFF_FFFF, 1'b0);
    chk("R10 illegal pulse", {31'd0, illegal_op}, 32'd1);
    @(negedge clk);
    chk("R10 pulse ends", {31'd0, illegal_op}, 32'd0);
    read_entry(7'd1, rd);
    chk("R10 entry kept", rd, 32'h0000_0485);
    cfg_write(1'b1, 7'd0, 32'h0000_0000, 1'b0);

    // Vector walk (enable still on proves R10 for the control write)
    for (int i = 0; i < NV; i++) begin
      xlate(VEC[i][35:34], VEC[i][33:18]);
      chk($sformatf("R%0d vec%0d pa", VEC[i][39:36], i), {16'd0, rsp_pa}, {16'd0, VEC[i][15:0]});
      chk($sformatf("R%0d vec%0d faults", VEC[i][39:36], i),
          {30'd0, rsp_seg_fault, rsp_page_fault}, {30'd0, VEC[i][17], VEC[i][16]});
    end
    @(negedge clk);
    chk("R2 idle", {31'd0, rsp_vld}, 32'd0);

    // R12: loads, fetches and faulting stores leave dirty alone
    read_entry(7'd1, rd);
    chk("R12 page1", rd, 32'h0000_0485);
    read_entry(7'd3, rd);
    chk("R12 page3", rd, 32'h0000_1D83);
    read_entry(7'd2, rd);
    chk("R12 page2 clean", rd, 32'h0000_1CFF);

    // R8: permitted resident store marks dirty
    xlate(2'd1, 16'h0400);
    chk("R8 store pa", {16'd0, rsp_pa}, 32'hFE00);
    read_entry(7'd2, rd);
    chk("R8 dirty set", rd, 32'h0000_1EFF);

    // R12: store while disabled changes nothing
    cfg_write(1'b0, 7'd2, 32'h0000_1CFF, 1'b1);
    cfg_write(1'b1, 7'd0, 32'h0000_0000, 1'b1);
    xlate(2'd1, 16'h0400);
    chk("R3 disabled store pa", {16'd0, rsp_pa}, 32'h0400);
    read_entry(7'd2, rd);
    chk("R12 disabled store", rd, 32'h0000_1CFF);
    cfg_write(1'b1, 7'd0, 32'h0000_0001, 1'b1);

    // R11: store and rewrite of the same page in one cycle
    @(negedge clk);
    req_vld = 1'b1; req_op = 2'd1; req_va = 16'h0400;
    cfg_we = 1'b1; cfg_ctl = 1'b0; cfg_priv = 1'b1; cfg_idx = 7'd2; cfg_wdata = 32'h0000_0C89;
    @(negedge clk);
    req_vld = 1'b0; cfg_we = 1'b0; cfg_priv = 1'b0;
    chk("R11 old frame used", {16'd0, rsp_pa}, 32'hFE00);
    chk("R11 no fault", {30'd0, rsp_seg_fault, rsp_page_fault}, 32'd0);
    read_entry(7'd2, rd);
    chk("R11 written value kept", rd, 32'h0000_0C89);
    xlate(2'd1, 16'h0410);
    chk("R11 new frame", {16'd0, rsp_pa}, 32'h1210);
    read_entry(7'd2, rd);
    chk("R8 dirty on new entry", rd, 32'h0000_0E89);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule